// File: doc/BRIEF.md
# Three-Wide Register Rename Stage

This block sits between instruction delivery and scheduling in an out-of-order core. Each clock it takes a group of up to three micro-operations. Each micro-operation carries two architectural source indices, an optional architectural destination and a valid bit. The block maps the eight architectural integer registers onto a pool of 128 physical registers. For every valid lane it returns the physical tags of both sources. For every lane that writes a destination it returns a freshly allocated physical tag and the tag that destination held before. Every valid lane also gets a sequence number that names its reorder slot and gives its age.

Two alias tables hold the mappings. The speculative table holds the newest mapping of each architectural register and is written when a group is renamed. The committed table is written when micro-operations retire in program order. Retirement sends the physical register that a destination used to map to back to an unordered free pool. No result data moves between structures at any point.

A flush copies the committed table over the speculative one and discards every reorder slot in flight. It also rebuilds the free pool from the registers that the committed table does not reference. When the group asks for more free registers or reorder slots than remain, the whole group waits, and the caller holds it until the stall clears.

Top module: `rn_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both tables, physical registers 8 to 127 are free, and the first sequence number issued is 0.
- R2: Each lane with valid=1 and dst_en=1 receives a distinct destination tag. The tags are the lowest-numbered free physical registers, handed out in ascending lane order. Lanes without a destination consume no register.
- R3: A source tag comes from the speculative table. When an earlier lane of the same group writes that architectural register, the source takes the tag that lane was just given; if several earlier lanes write it, the nearest one wins.
- R4: The old-tag output of a destination lane is its previous mapping, counting an earlier lane of the same group that wrote the same register.
- R5: Valid lanes receive consecutive sequence numbers in lane order, and the number after 125 is 0.
- R6: When the destination lanes of a group outnumber the free registers, ren_stall is 1 and the group changes no table, pool or sequence state.
- R7: When the valid lanes outnumber the unused reorder slots (126 minus those in flight), ren_stall is 1 and the group changes no state.
- R8: A retiring lane with ret_valid=1 and ret_dst_en=1 writes ret_new_tag into the committed table and returns ret_old_tag to the free pool. Lanes take effect in order, and each valid retiring lane releases one reorder slot.
- R9: On flush the speculative table becomes a copy of the committed table, the next sequence number restarts at the oldest unretired slot, and the free pool becomes every register the committed table does not reference.
- R10: During a flush cycle ren_stall is 1, and both the rename and the retire inputs of that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restore speculative state from the committed state |
| ren_valid | input | 3 | Lane holds a micro-operation |
| ren_dst_en | input | 3 | Lane writes a destination |
| ren_src_a | input | 9 | First source index, 3 bits per lane |
| ren_src_b | input | 9 | Second source index, 3 bits per lane |
| ren_dst | input | 9 | Destination index, 3 bits per lane |
| ren_stall | output | 1 | Group not accepted this cycle |
| ren_src_a_tag | output | 21 | Physical tag of the first source, 7 bits per lane |
| ren_src_b_tag | output | 21 | Physical tag of the second source, 7 bits per lane |
| ren_dst_tag | output | 21 | Newly allocated destination tag, 7 bits per lane |
| ren_old_tag | output | 21 | Previous mapping of the destination, 7 bits per lane |
| ren_seq | output | 21 | Reorder sequence number, 7 bits per lane |
| ret_valid | input | 3 | Lane retires a micro-operation (oldest first) |
| ret_dst_en | input | 3 | Retiring lane wrote a destination |
| ret_dst | input | 9 | Architectural destination of the retiring lane |
| ret_new_tag | input | 21 | Tag that becomes committed |
| ret_old_tag | input | 21 | Superseded tag returned to the pool |

## Verification
The assertions check on every cycle that an accepted group gets as many distinct registers as it has destination lanes, and that the free count moves exactly by allocations and releases. They also check that the in-flight count never exceeds the reorder depth, that a flush empties the reorder window and restores 120 free registers, and that a flush always stalls renaming. Which registers are chosen, how tags forward within a group, how sequence numbers wrap, and how a flush restores committed mappings while ignoring same-cycle requests are all visible only at the ports. The bench's directed scenarios show those.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // Sum of two ring positions, folded back into [0, depth)
  function automatic int ring_add(input int base, input int inc, input int depth);
    int s;
    s = base + inc;
    return (s >= depth) ? s - depth : s;
  endfunction

  // Number of set bits among the lanes below lane k
  function automatic int ones_below(input logic [7:0] v, input int k);
    int n;
    n = 0;
    for (int i = 0; i < 8; i++)
      if (i < k && v[i]) n++;
    return n;
  endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int LANES     = 3,
  parameter int ARCH_REGS = 8,
  parameter int PTAG_W    = 7,
  localparam int AW       = $clog2(ARCH_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_all,
  input  logic [ARCH_REGS*PTAG_W-1:0] load_vec,
  input  logic [LANES-1:0]          wr_en,
  input  logic [LANES*AW-1:0]       wr_idx,
  input  logic [LANES*PTAG_W-1:0]   wr_tag,
  output logic [ARCH_REGS*PTAG_W-1:0] map_flat
);

  logic [PTAG_W-1:0] map_q [ARCH_REGS];

  // Lane order: a later lane writing the same entry overrides an earlier one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PTAG_W'(i);
    end else if (load_all) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= load_vec[i*PTAG_W +: PTAG_W];
    end else begin
      for (int k = 0; k < LANES; k++)
        if (wr_en[k]) map_q[wr_idx[k*AW +: AW]] <= wr_tag[k*PTAG_W +: PTAG_W];
    end
  end

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_out
    assign map_flat[g*PTAG_W +: PTAG_W] = map_q[g];
  end

endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int LANES     = 3,
  parameter int PHYS_REGS = 128,
  parameter int ARCH_REGS = 8,
  localparam int PW       = $clog2(PHYS_REGS),
  localparam int FW       = $clog2(PHYS_REGS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rebuild,
  input  logic [PHYS_REGS-1:0] rebuild_mask,
  input  logic [PHYS_REGS-1:0] alloc_mask,
  input  logic [PHYS_REGS-1:0] ret_mask,
  output logic [LANES*PW-1:0]  pick_flat,
  output logic [FW-1:0]        free_cnt
);

  logic [PHYS_REGS-1:0] free_q;
  logic [PHYS_REGS-1:0] scan [LANES+1];

  function automatic logic [PW-1:0] lowest_set(input logic [PHYS_REGS-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--)
      if (v[i]) r = PW'(i);
    return r;
  endfunction

  assign scan[0] = free_q;

  // Successive candidates: each stage removes the register the previous one chose
  for (genvar k = 0; k < LANES; k++) begin : g_pick
    logic [PW-1:0] pick;
    assign pick = lowest_set(scan[k]);
    assign pick_flat[k*PW +: PW] = pick;
    assign scan[k+1] = scan[k] & ~(PHYS_REGS'(1) << pick);
  end

  assign free_cnt = FW'($countones(free_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_REGS; i++) free_q[i] <= (i >= ARCH_REGS);
    end else if (rebuild) begin
      free_q <= rebuild_mask;
    end else begin
      free_q <= (free_q & ~alloc_mask) | ret_mask;
    end
  end

endmodule

// File: rtl/rn_seq_ring.sv
module rn_seq_ring
  import rn_pkg::*;
#(
  parameter int LANES     = 3,
  parameter int ROB_DEPTH = 126,
  localparam int SW       = $clog2(ROB_DEPTH),
  localparam int CW       = $clog2(ROB_DEPTH + 1),
  localparam int NW       = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [NW-1:0] alloc_n,
  input  logic [NW-1:0] ret_n,
  output logic [SW-1:0] tail,
  output logic [CW-1:0] cnt
);

  logic [SW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      tail_q <= head_q;
      cnt_q  <= '0;
    end else begin
      tail_q <= SW'(ring_add(int'(tail_q), int'(alloc_n), ROB_DEPTH));
      head_q <= SW'(ring_add(int'(head_q), int'(ret_n), ROB_DEPTH));
      cnt_q  <= CW'(int'(cnt_q) + int'(alloc_n) - int'(ret_n));
    end
  end

  assign tail = tail_q;
  assign cnt  = cnt_q;

endmodule

// File: rtl/rn_renamer.sv
module rn_renamer
  import rn_pkg::*;
#(
  parameter int LANES     = 3,
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 128,
  parameter int ROB_DEPTH = 126,
  localparam int AW       = $clog2(ARCH_REGS),
  localparam int PW       = $clog2(PHYS_REGS),
  localparam int SW       = $clog2(ROB_DEPTH),
  localparam int CW       = $clog2(ROB_DEPTH + 1),
  localparam int FW       = $clog2(PHYS_REGS + 1),
  localparam int NW       = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [LANES-1:0]    ren_valid,
  input  logic [LANES-1:0]    ren_dst_en,
  input  logic [LANES*AW-1:0] ren_src_a,
  input  logic [LANES*AW-1:0] ren_src_b,
  input  logic [LANES*AW-1:0] ren_dst,
  output logic                ren_stall,
  output logic [LANES*PW-1:0] ren_src_a_tag,
  output logic [LANES*PW-1:0] ren_src_b_tag,
  output logic [LANES*PW-1:0] ren_dst_tag,
  output logic [LANES*PW-1:0] ren_old_tag,
  output logic [LANES*SW-1:0] ren_seq,
  input  logic [LANES-1:0]    ret_valid,
  input  logic [LANES-1:0]    ret_dst_en,
  input  logic [LANES*AW-1:0] ret_dst,
  input  logic [LANES*PW-1:0] ret_new_tag,
  input  logic [LANES*PW-1:0] ret_old_tag
);

  // ---------------- state holders ----------------
  logic [ARCH_REGS*PW-1:0] spec_flat, comm_flat;
  logic [PW-1:0]           spec_a [ARCH_REGS];
  logic [PW-1:0]           comm_a [ARCH_REGS];
  logic [LANES*PW-1:0]     pick_flat;
  logic [FW-1:0]           free_cnt;
  logic [SW-1:0]           tail;
  logic [CW-1:0]           rob_cnt;

  // ---------------- named internal events ----------------
  logic                 fire;
  logic                 ret_go;
  logic [NW-1:0]        need_dst;
  logic [NW-1:0]        need_rob;
  logic [NW-1:0]        alloc_take;
  logic [NW-1:0]        ret_give;
  logic [NW-1:0]        ret_n;
  logic [NW-1:0]        alloc_n;
  logic [LANES-1:0]     spec_we;
  logic [LANES-1:0]     comm_we;
  logic [PHYS_REGS-1:0] alloc_mask;
  logic [PHYS_REGS-1:0] ret_mask;
  logic [PHYS_REGS-1:0] rebuild_mask;

  logic [PW-1:0] sa_t [LANES];
  logic [PW-1:0] sb_t [LANES];
  logic [PW-1:0] dt_t [LANES];
  logic [PW-1:0] ot_t [LANES];
  logic [SW-1:0] sq_t [LANES];

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_unpack
    assign spec_a[g] = spec_flat[g*PW +: PW];
    assign comm_a[g] = comm_flat[g*PW +: PW];
  end

  // ---------------- per-lane rename with in-group forwarding ----------------
  always_comb begin
    int nd;
    int nv;
    nd = 0;
    nv = 0;
    for (int k = 0; k < LANES; k++) begin
      sa_t[k] = spec_a[ren_src_a[k*AW +: AW]];
      sb_t[k] = spec_a[ren_src_b[k*AW +: AW]];
      ot_t[k] = spec_a[ren_dst[k*AW +: AW]];
      dt_t[k] = pick_flat[nd*PW +: PW];
      sq_t[k] = SW'(ring_add(int'(tail), nv, ROB_DEPTH));
      for (int j = 0; j < k; j++) begin
        if (ren_valid[j] && ren_dst_en[j]) begin
          if (ren_dst[j*AW +: AW] == ren_src_a[k*AW +: AW]) sa_t[k] = dt_t[j];
          if (ren_dst[j*AW +: AW] == ren_src_b[k*AW +: AW]) sb_t[k] = dt_t[j];
          if (ren_dst[j*AW +: AW] == ren_dst[k*AW +: AW])   ot_t[k] = dt_t[j];
        end
      end
      if (ren_valid[k]) begin
        nv++;
        if (ren_dst_en[k]) nd++;
      end
    end
    need_dst = NW'(nd);
    need_rob = NW'(nv);
  end

  // ---------------- resource check ----------------
  assign ren_stall = flush
                   | (int'(need_dst) > int'(free_cnt))
                   | (int'(need_rob) > ROB_DEPTH - int'(rob_cnt));
  assign fire       = ~ren_stall & (|ren_valid);
  assign alloc_take = fire ? need_dst : '0;
  assign alloc_n    = fire ? need_rob : '0;

  always_comb begin
    alloc_mask = '0;
    for (int k = 0; k < LANES; k++)
      if (spec_we[k]) alloc_mask[dt_t[k]] = 1'b1;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign spec_we[k] = fire & ren_valid[k] & ren_dst_en[k];
    assign comm_we[k] = ret_go & ret_valid[k] & ret_dst_en[k];
    assign ren_src_a_tag[k*PW +: PW] = sa_t[k];
    assign ren_src_b_tag[k*PW +: PW] = sb_t[k];
    assign ren_dst_tag[k*PW +: PW]   = dt_t[k];
    assign ren_old_tag[k*PW +: PW]   = ot_t[k];
    assign ren_seq[k*SW +: SW]       = sq_t[k];
  end

  // ---------------- retirement ----------------
  assign ret_go   = ~flush;
  assign ret_give = NW'($countones(comm_we));
  assign ret_n    = ret_go ? NW'($countones(ret_valid)) : '0;

  always_comb begin
    ret_mask = '0;
    for (int k = 0; k < LANES; k++)
      if (comm_we[k]) ret_mask[ret_old_tag[k*PW +: PW]] = 1'b1;
  end

  // Registers the committed table does not reference become free on flush
  always_comb begin
    rebuild_mask = '1;
    for (int a = 0; a < ARCH_REGS; a++) rebuild_mask[comm_a[a]] = 1'b0;
  end

  // ---------------- submodules ----------------
  rn_map_table #(.LANES(LANES), .ARCH_REGS(ARCH_REGS), .PTAG_W(PW)) u_spec_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_all (flush),
    .load_vec (comm_flat),
    .wr_en    (spec_we),
    .wr_idx   (ren_dst),
    .wr_tag   (ren_dst_tag),
    .map_flat (spec_flat)
  );

  rn_map_table #(.LANES(LANES), .ARCH_REGS(ARCH_REGS), .PTAG_W(PW)) u_comm_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_all (1'b0),
    .load_vec (comm_flat),
    .wr_en    (comm_we),
    .wr_idx   (ret_dst),
    .wr_tag   (ret_new_tag),
    .map_flat (comm_flat)
  );

  rn_free_pool #(.LANES(LANES), .PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS)) u_pool (
    .clk          (clk),
    .rst_n        (rst_n),
    .rebuild      (flush),
    .rebuild_mask (rebuild_mask),
    .alloc_mask   (alloc_mask),
    .ret_mask     (ret_mask),
    .pick_flat    (pick_flat),
    .free_cnt     (free_cnt)
  );

  rn_seq_ring #(.LANES(LANES), .ROB_DEPTH(ROB_DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .alloc_n (alloc_n),
    .ret_n   (ret_n),
    .tail    (tail),
    .cnt     (rob_cnt)
  );

endmodule

// File: rtl/rn_renamer_chk.sv
module rn_renamer_chk #(
  parameter int LANES     = 3,
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 128,
  parameter int ROB_DEPTH = 126,
  localparam int CW       = $clog2(ROB_DEPTH + 1),
  localparam int FW       = $clog2(PHYS_REGS + 1),
  localparam int NW       = $clog2(LANES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 ren_stall,
  input logic                 fire,
  input logic [PHYS_REGS-1:0] alloc_mask,
  input logic [NW-1:0]        need_dst,
  input logic [NW-1:0]        alloc_take,
  input logic [NW-1:0]        ret_give,
  input logic [FW-1:0]        free_cnt,
  input logic [CW-1:0]        rob_cnt
);

  // R2
  dst_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $countones(alloc_mask) == int'(need_dst));

  // R6
  pool_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(free_cnt) ==
      int'($past(free_cnt)) - int'($past(alloc_take)) + int'($past(ret_give)));

  // R7
  rob_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rob_cnt) <= ROB_DEPTH);

  // R9
  flush_reclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rob_cnt == '0) && (int'(free_cnt) == PHYS_REGS - ARCH_REGS));

  // R10
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ren_stall);

endmodule

bind rn_renamer rn_renamer_chk #(
  .LANES(LANES), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .ROB_DEPTH(ROB_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .ren_stall  (ren_stall),
  .fire       (fire),
  .alloc_mask (alloc_mask),
  .need_dst   (need_dst),
  .alloc_take (alloc_take),
  .ret_give   (ret_give),
  .free_cnt   (free_cnt),
  .rob_cnt    (rob_cnt)
);

// File: tb/rn_renamer_bench.sv
`timescale 1ns/1ps
module rn_renamer_bench;
  localparam int L  = 3;
  localparam int AW = 3;
  localparam int PW = 7;
  localparam int SW = 7;

  logic clk = 1'b0;
  logic rst_n, flush;
  logic [L-1:0]    ren_valid, ren_dst_en, ret_valid, ret_dst_en;
  logic [L*AW-1:0] ren_src_a, ren_src_b, ren_dst, ret_dst;
  logic [L*PW-1:0] ret_new_tag, ret_old_tag;
  logic            ren_stall;
  logic [L*PW-1:0] ren_src_a_tag, ren_src_b_tag, ren_dst_tag, ren_old_tag;
  logic [L*SW-1:0] ren_seq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rn_renamer u_rn_renamer (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ren_valid(ren_valid), .ren_dst_en(ren_dst_en),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
    .ren_stall(ren_stall),
    .ren_src_a_tag(ren_src_a_tag), .ren_src_b_tag(ren_src_b_tag),
    .ren_dst_tag(ren_dst_tag), .ren_old_tag(ren_old_tag), .ren_seq(ren_seq),
    .ret_valid(ret_valid), .ret_dst_en(ret_dst_en), .ret_dst(ret_dst),
    .ret_new_tag(ret_new_tag), .ret_old_tag(ret_old_tag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; ren_valid = '0; ren_dst_en = '0; ren_src_a = '0; ren_src_b = '0;
    ren_dst = '0; ret_valid = '0; ret_dst_en = '0; ret_dst = '0;
    ret_new_tag = '0; ret_old_tag = '0;
  endtask

  task automatic lane(input int k, input bit v, input bit de, input int a, input int b, input int d);
    ren_valid[k] = v; ren_dst_en[k] = de;
    ren_src_a[k*AW +: AW] = AW'(a); ren_src_b[k*AW +: AW] = AW'(b); ren_dst[k*AW +: AW] = AW'(d);
  endtask

  task automatic rlane(input int k, input bit de, input int d, input int nt, input int ot);
    ret_valid[k] = 1'b1; ret_dst_en[k] = de; ret_dst[k*AW +: AW] = AW'(d);
    ret_new_tag[k*PW +: PW] = PW'(nt); ret_old_tag[k*PW +: PW] = PW'(ot);
  endtask

  function automatic int sa(input int k); return int'(ren_src_a_tag[k*PW +: PW]); endfunction
  function automatic int sb(input int k); return int'(ren_src_b_tag[k*PW +: PW]); endfunction
  function automatic int dt(input int k); return int'(ren_dst_tag[k*PW +: PW]); endfunction
  function automatic int ot(input int k); return int'(ren_old_tag[k*PW +: PW]); endfunction
  function automatic int sq(input int k); return int'(ren_seq[k*SW +: SW]); endfunction

  task automatic settle(); #1; endtask
  task automatic advance(); @(negedge clk); idle(); endtask

  task automatic reset_dut();
    rst_n = 0; idle();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  // R1 R2 R3 R4 R5: first group after reset with in-group forwarding
  task automatic t_first_group();
    lane(0, 1, 1, 3, 5, 2);
    lane(1, 1, 1, 2, 7, 2);
    lane(2, 1, 0, 2, 0, 0);
    settle();
    check("R6", "stall", int'(ren_stall), 0);
    check("R1", "lane0 src_a", sa(0), 3);
    check("R1", "lane0 src_b", sb(0), 5);
    check("R2", "lane0 dst", dt(0), 8);
    check("R1", "lane0 old", ot(0), 2);
    check("R1", "lane0 seq", sq(0), 0);
    check("R3", "lane1 src_a fwd", sa(1), 8);
    check("R3", "lane1 src_b", sb(1), 7);
    check("R2", "lane1 dst", dt(1), 9);
    check("R4", "lane1 old fwd", ot(1), 8);
    check("R3", "lane2 src_a nearest", sa(2), 9);
    check("R5", "lane2 seq", sq(2), 2);
    advance();
  endtask

  // R2 R3 R5: lane without destination consumes no register
  task automatic t_gap_group();
    lane(0, 1, 0, 2, 2, 0);
    lane(1, 1, 1, 1, 0, 1);
    settle();
    check("R3", "table updated", sa(0), 9);
    check("R2", "skip non-dst lane", dt(1), 10);
    check("R4", "old from table", ot(1), 1);
    check("R5", "lane0 seq", sq(0), 3);
    check("R5", "lane1 seq", sq(1), 4);
    advance();
  endtask

  // R8 R9 R10: retire, flush with ignored requests, restore
  task automatic t_retire_flush();
    rlane(0, 1, 2, 8, 2);
    rlane(1, 1, 2, 9, 8);
    rlane(2, 0, 0, 0, 0);
    advance();
    flush = 1;
    lane(0, 1, 1, 0, 0, 6);
    rlane(0, 1, 6, 100, 6);
    settle();
    check("R10", "stall during flush", int'(ren_stall), 1);
    advance();
    lane(0, 1, 1, 2, 1, 0);
    lane(1, 1, 1, 6, 0, 5);
    settle();
    check("R9", "committed r2", sa(0), 9);
    check("R9", "discarded r1", sb(0), 1);
    check("R9", "rebuilt pool lowest", dt(0), 2);
    check("R9", "old r0", ot(0), 0);
    check("R9", "seq from head", sq(0), 3);
    check("R10", "flush rename ignored", sa(1), 6);
    check("R9", "second pick", dt(1), 8);
    advance();
    flush = 1;
    advance();
    lane(0, 1, 1, 6, 2, 3);
    settle();
    check("R10", "flush retire ignored", sa(0), 6);
    check("R8", "committed r2 kept", sb(0), 9);
    check("R9", "discards repeated", dt(0), 2);
    check("R9", "seq again", sq(0), 3);
    advance();
  endtask

  // R6 R8: exhaust the free pool
  task automatic t_pool_empty();
    reset_dut();
    for (int g = 0; g < 40; g++) begin
      lane(0, 1, 1, 0, 0, 0);
      lane(1, 1, 1, 0, 0, 1);
      lane(2, 1, 1, 0, 0, 2);
      settle();
      if (g == 39) begin
        check("R2", "last free reg", dt(2), 127);
        check("R5", "seq at 119", sq(2), 119);
      end
      advance();
    end
    lane(0, 1, 1, 0, 0, 3);
    settle();
    check("R6", "stall on empty pool", int'(ren_stall), 1);
    advance();
    lane(0, 1, 0, 0, 0, 0);
    settle();
    check("R6", "no-dst proceeds", int'(ren_stall), 0);
    check("R6", "stalled group took no seq", sq(0), 120);
    advance();
    rlane(0, 1, 0, 8, 0);
    advance();
    lane(0, 1, 1, 0, 0, 4);
    settle();
    check("R8", "stall cleared", int'(ren_stall), 0);
    check("R8", "returned reg reused", dt(0), 0);
    check("R4", "old of r4", ot(0), 4);
    check("R5", "seq 121", sq(0), 121);
    advance();
  endtask

  // R5 R7: fill the reorder window and wrap
  task automatic t_rob_full();
    reset_dut();
    for (int g = 0; g < 42; g++) begin
      lane(0, 1, 0, 0, 0, 0);
      lane(1, 1, 0, 0, 0, 0);
      lane(2, 1, 0, 0, 0, 0);
      settle();
      if (g == 41) check("R5", "seq 125", sq(2), 125);
      advance();
    end
    lane(0, 1, 0, 0, 0, 0);
    settle();
    check("R7", "stall when full", int'(ren_stall), 1);
    advance();
    rlane(0, 0, 0, 0, 0);
    advance();
    lane(0, 1, 0, 0, 0, 0);
    lane(1, 1, 0, 0, 0, 0);
    settle();
    check("R7", "two lanes one slot", int'(ren_stall), 1);
    advance();
    lane(0, 1, 0, 0, 0, 0);
    settle();
    check("R7", "one slot ok", int'(ren_stall), 0);
    check("R5", "seq wraps", sq(0), 0);
    advance();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    reset_dut();
    t_first_group();
    t_gap_group();
    t_retire_flush();
    t_pool_empty();
    t_rob_full();
    done = 1;
    finish_run();
  end

endmodule